// File: doc/BRIEF.md
# Periodic Event Generator with Interrupt Flag and Timed Pulse

This block turns one of four incoming timebase strobes (a 64 Hz tick, a seconds tick, a minutes tick and an hours tick) into a periodic event. A two-bit period select picks the strobe. A mode bit then decides how each event appears. In interrupt mode, each event sets a sticky flag. Software clears that flag by writing zero to it, and the active-low output pin stays asserted while the flag is set. In pulse mode, each event drives the same pin low for a fixed number of clock cycles. In that mode the flag is a live copy of the pulse: it reads one exactly while the pin is low, and a write of zero cuts the pulse short.

A mask bit stops new events from taking effect in either mode. When the mode bit or the period select changes, any pending flag or pulse is dropped, so a stale event never carries over into the new configuration. Generating the timebase strobes and keeping the calendar belong to other blocks.

Top module: `pfi_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, `flag_rd` is 0 and `evt_n` is 1.
- R2: `period_sel` picks the strobe: 00 gives `tick_fast`, 01 gives `tick_sec`, 10 gives `tick_min` and 11 gives `tick_hour`. A strobe that is not selected has no effect on `flag_rd` or `evt_n`.
- R3: With `irq_mode`=1 and `mask`=0, a selected strobe sets `flag_rd` to 1 from the next cycle on. `evt_n` is 0 for as long as the flag stays set.
- R4: With `irq_mode`=1, a write (`flag_wr`=1) with `flag_wdata`=0 clears the flag in the next cycle. A write with `flag_wdata`=1 leaves the flag unchanged.
- R5: With `mask`=1, a selected strobe neither sets the flag nor starts a pulse.
- R6: With `irq_mode`=0 and `mask`=0, a selected strobe drives `evt_n` low from the next cycle for exactly `PULSE_LEN` cycles. During that time `flag_rd` equals the inverse of `evt_n`.
- R7: With `irq_mode`=0, a write of 0 to the flag during a pulse returns `evt_n` to 1 and `flag_rd` to 0 in the next cycle.
- R8: A selected, unmasked strobe in the same cycle as a write of 0 wins. In interrupt mode the flag is set. In pulse mode a full `PULSE_LEN` pulse starts.
- R9: A change of `irq_mode` or `period_sel` clears the flag and any pulse in the next cycle. A strobe in the same cycle as the change is discarded.
- R10: A selected strobe that arrives while a pulse is running restarts the pulse, so it lasts `PULSE_LEN` cycles from that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_fast | input | 1 | One-cycle strobe at 64 Hz |
| tick_sec | input | 1 | One-cycle strobe once per second |
| tick_min | input | 1 | One-cycle strobe once per minute |
| tick_hour | input | 1 | One-cycle strobe once per hour |
| period_sel | input | 2 | Period select (00 fast, 01 sec, 10 min, 11 hour) |
| irq_mode | input | 1 | 1 = interrupt flag mode, 0 = timed pulse mode |
| mask | input | 1 | 1 blocks new events |
| flag_wr | input | 1 | Write strobe for the flag |
| flag_wdata | input | 1 | Value written to the flag (only 0 acts) |
| flag_rd | output | 1 | Flag readback |
| evt_n | output | 1 | Active-low event output pin |

## Verification
The race that matters is a selected strobe landing in the same cycle as a write of zero to the flag. The bench drives both on one clock edge in each mode. In interrupt mode it expects the flag to read one afterwards. In pulse mode, where the write arrives partway through a pulse, it counts the low cycles that follow and expects a full `PULSE_LEN`. A second collision, a strobe in the same cycle as a change of period select, is expected to leave the pin high.

// File: rtl/pfi_pkg.sv
// Shared types for the periodic event generator.
package pfi_pkg;
    // Period select code; the numeric values are the software-visible encoding.
    typedef enum logic [1:0] {
        PER_FAST = 2'b00,
        PER_SEC  = 2'b01,
        PER_MIN  = 2'b10,
        PER_HOUR = 2'b11
    } period_e;
endpackage

// File: rtl/pfi_rate_mux.sv
// Picks the timebase strobe named by the period select and gates it with
// the mask. Assumes each strobe is high for one clock cycle.
module pfi_rate_mux
    import pfi_pkg::*;
(
    input  logic    tick_fast,
    input  logic    tick_sec,
    input  logic    tick_min,
    input  logic    tick_hour,
    input  period_e sel,
    input  logic    mask,
    output logic    evt
);
    logic picked;

    // Route the selected strobe.
    always_comb begin
        unique case (sel)
            PER_FAST: picked = tick_fast;
            PER_SEC:  picked = tick_sec;
            PER_MIN:  picked = tick_min;
            PER_HOUR: picked = tick_hour;
            default:  picked = 1'b0;
        endcase
    end

    assign evt = picked & ~mask;
endmodule

// File: rtl/pfi_cfg_watch.sv
// Detects a change of mode or period select by comparing them with the
// values held in the previous cycle. Assumes reset values of zero.
module pfi_cfg_watch #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic [SEL_W-1:0] sel,
    output logic             chg
);
    logic             mode_q;
    logic [SEL_W-1:0] sel_q;

    // Remember last cycle's configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            mode_q <= mode;
            sel_q  <= sel;
        end
    end

    assign chg = (mode != mode_q) || (sel != sel_q);
endmodule

// File: rtl/pfi_irq_latch.sv
// Sticky interrupt flag. Priority: clear on config change, then set by an
// event, then clear by a software write of zero.
module pfi_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    input  logic cancel,
    output logic flag
);
    // Flag state update.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (clr)    flag <= 1'b0;
        else if (set)    flag <= 1'b1;
        else if (cancel) flag <= 1'b0;
    end
endmodule

// File: rtl/pfi_pulse_timer.sv
// Down-counter that holds a pulse active for LEN cycles after a start.
// A restart reloads the count. Assumes LEN >= 1.
module pfi_pulse_timer #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic cancel,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    // Load, cancel or count down the remaining pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (clr)         cnt <= '0;
        else if (start)       cnt <= CW'(LEN);
        else if (cancel)      cnt <= '0;
        else if (cnt != '0)   cnt <= cnt - CW'(1);
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/pfi_unit.sv
// Periodic event generator top. Selects a timebase strobe and presents
// it either as a sticky interrupt flag or as a timed low pulse on evt_n.
// The flag readback follows the active mode. Synchronous active-low reset.
module pfi_unit
    import pfi_pkg::*;
#(
    parameter int PULSE_LEN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_fast,
    input  logic       tick_sec,
    input  logic       tick_min,
    input  logic       tick_hour,
    input  logic [1:0] period_sel,
    input  logic       irq_mode,
    input  logic       mask,
    input  logic       flag_wr,
    input  logic       flag_wdata,
    output logic       flag_rd,
    output logic       evt_n
);
    logic evt;
    logic cfg_chg;
    logic cancel;
    logic irq_flag;
    logic pls_act;

    assign cancel = flag_wr & ~flag_wdata;

    pfi_rate_mux u_mux (
        .tick_fast (tick_fast),
        .tick_sec  (tick_sec),
        .tick_min  (tick_min),
        .tick_hour (tick_hour),
        .sel       (period_e'(period_sel)),
        .mask      (mask),
        .evt       (evt)
    );

    pfi_cfg_watch #(.SEL_W(2)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (irq_mode),
        .sel   (period_sel),
        .chg   (cfg_chg)
    );

    pfi_irq_latch u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_chg),
        .set    (evt & irq_mode),
        .cancel (cancel & irq_mode),
        .flag   (irq_flag)
    );

    pfi_pulse_timer #(.LEN(PULSE_LEN)) u_pls (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_chg),
        .start  (evt & ~irq_mode),
        .cancel (cancel & ~irq_mode),
        .active (pls_act)
    );

    assign flag_rd = irq_mode ? irq_flag : pls_act;
    assign evt_n   = ~flag_rd;
endmodule

// File: rtl/pfi_unit_chk.sv
// Assertion checker for pfi_unit, attached by bind below.
module pfi_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_mode,
    input logic mask,
    input logic flag_wr,
    input logic flag_wdata,
    input logic flag_rd,
    input logic evt_n
);
    // R1: reset leaves the unit idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (evt_n && !flag_rd));

    // R3 / R6: the pin is the inverse of the flag readback.
    p_pin_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd == !evt_n);

    // R5: with the mask set, a clear flag cannot rise.
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !flag_rd) |=> !flag_rd);

    // R4: a write of zero in interrupt mode clears the flag.
    p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode && mask && flag_wr && !flag_wdata) |=> !flag_rd);

    // R7: a write of zero in pulse mode ends the pulse.
    p_pulse_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_mode && mask && flag_wr && !flag_wdata) |=> evt_n);
endmodule

bind pfi_unit pfi_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_mode   (irq_mode),
    .mask       (mask),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .flag_rd    (flag_rd),
    .evt_n      (evt_n)
);

// File: tb/sim_pfi_unit.sv
module sim_pfi_unit;
    localparam int PLEN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tk = '0;
    logic [1:0] period_sel = '0;
    logic       irq_mode = 1'b0;
    logic       mask = 1'b0;
    logic       flag_wr = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       flag_rd;
    logic       evt_n;
    int         total = 0;
    int         bad = 0;

    always #2 clk = ~clk;

    pfi_unit #(.PULSE_LEN(PLEN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tick_fast(tk[0]), .tick_sec(tk[1]), .tick_min(tk[2]), .tick_hour(tk[3]),
        .period_sel(period_sel), .irq_mode(irq_mode), .mask(mask),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .flag_rd(flag_rd), .evt_n(evt_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, return at the next falling edge.
    task automatic cyc(input logic [3:0] t, input logic wr, input logic wd);
        tk = t; flag_wr = wr; flag_wdata = wd;
        @(negedge clk);
        tk = '0; flag_wr = 1'b0; flag_wdata = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(4'b0, 1'b0, 1'b0);
    endtask

    task automatic config_to(input logic m, input logic [1:0] s, input logic mk);
        irq_mode = m; period_sel = s; mask = mk;
        idle(2);
        cyc(4'b0, 1'b1, 1'b0);
        idle(1);
    endtask

    // Count the consecutive low cycles on evt_n, checking flag mirror.
    task automatic measure(output int n, input string tag);
        n = 0;
        while (!evt_n && n < 50) begin
            chk(flag_rd == 1'b1, tag, flag_rd, 1);
            n++;
            cyc(4'b0, 1'b0, 1'b0);
        end
        chk(flag_rd == 1'b0, tag, flag_rd, 0);
    endtask

    task automatic t_reset;
        chk(flag_rd == 1'b0, "R1 flag", flag_rd, 0);
        chk(evt_n == 1'b1, "R1 pin", evt_n, 1);
    endtask

    task automatic t_select;
        for (int s = 0; s < 4; s++) begin
            config_to(1'b1, 2'(s), 1'b0);
            for (int b = 0; b < 4; b++) begin
                cyc(4'(1 << b), 1'b0, 1'b0);
                chk(flag_rd == (b == s), "R2 select", flag_rd, int'(b == s));
                cyc(4'b0, 1'b1, 1'b0);
            end
        end
    endtask

    task automatic t_irq;
        config_to(1'b1, 2'b01, 1'b0);
        cyc(4'b0010, 1'b0, 1'b0);
        chk(flag_rd == 1'b1, "R3 set", flag_rd, 1);
        idle(5);
        chk(evt_n == 1'b0, "R3 pin held", evt_n, 0);
        cyc(4'b0, 1'b1, 1'b1);
        chk(flag_rd == 1'b1, "R4 write one", flag_rd, 1);
        cyc(4'b0, 1'b1, 1'b0);
        chk(flag_rd == 1'b0, "R4 clear", flag_rd, 0);
        chk(evt_n == 1'b1, "R4 pin", evt_n, 1);
    endtask

    task automatic t_mask;
        config_to(1'b1, 2'b00, 1'b1);
        cyc(4'b0001, 1'b0, 1'b0);
        chk(flag_rd == 1'b0, "R5 irq masked", flag_rd, 0);
        config_to(1'b0, 2'b00, 1'b1);
        cyc(4'b0001, 1'b0, 1'b0);
        chk(evt_n == 1'b1, "R5 pulse masked", evt_n, 1);
        idle(2);
        chk(evt_n == 1'b1, "R5 pulse masked later", evt_n, 1);
    endtask

    task automatic t_pulse;
        int n;
        config_to(1'b0, 2'b10, 1'b0);
        cyc(4'b0100, 1'b0, 1'b0);
        measure(n, "R6 mirror");
        chk(n == PLEN, "R6 length", n, PLEN);
    endtask

    task automatic t_cancel;
        config_to(1'b0, 2'b11, 1'b0);
        cyc(4'b1000, 1'b0, 1'b0);
        idle(2);
        chk(evt_n == 1'b0, "R7 running", evt_n, 0);
        cyc(4'b0, 1'b1, 1'b0);
        chk(evt_n == 1'b1, "R7 cancelled pin", evt_n, 1);
        chk(flag_rd == 1'b0, "R7 cancelled flag", flag_rd, 0);
    endtask

    task automatic t_collide;
        int n;
        config_to(1'b1, 2'b00, 1'b0);
        cyc(4'b0001, 1'b0, 1'b0);
        cyc(4'b0001, 1'b1, 1'b0);
        chk(flag_rd == 1'b1, "R8 irq event wins", flag_rd, 1);
        config_to(1'b0, 2'b00, 1'b0);
        cyc(4'b0001, 1'b0, 1'b0);
        idle(3);
        cyc(4'b0001, 1'b1, 1'b0);
        measure(n, "R8 pulse mirror");
        chk(n == PLEN, "R8 pulse event wins", n, PLEN);
    endtask

    task automatic t_cfg;
        config_to(1'b1, 2'b01, 1'b0);
        cyc(4'b0010, 1'b0, 1'b0);
        chk(flag_rd == 1'b1, "R9 pre set", flag_rd, 1);
        period_sel = 2'b10;
        cyc(4'b0100, 1'b0, 1'b0);
        chk(flag_rd == 1'b0, "R9 sel change clears", flag_rd, 0);
        idle(1);
        chk(flag_rd == 1'b0, "R9 strobe discarded", flag_rd, 0);
        cyc(4'b0100, 1'b0, 1'b0);
        chk(flag_rd == 1'b1, "R9 re-armed", flag_rd, 1);
        irq_mode = 1'b0;
        cyc(4'b0100, 1'b0, 1'b0);
        chk(evt_n == 1'b1, "R9 mode change", evt_n, 1);
        idle(2);
        chk(evt_n == 1'b1, "R9 mode strobe discarded", evt_n, 1);
    endtask

    task automatic t_retrig;
        int n;
        config_to(1'b0, 2'b01, 1'b0);
        cyc(4'b0010, 1'b0, 1'b0);
        idle(PLEN - 3);
        cyc(4'b0010, 1'b0, 1'b0);
        measure(n, "R10 mirror");
        chk(n == PLEN, "R10 restart", n, PLEN);
    endtask

    initial begin
        int wd = 0;
        while (wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        chk(1'b0, "watchdog", wd, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_select();
        t_irq();
        t_mask();
        t_pulse();
        t_cancel();
        t_collide();
        t_cfg();
        t_retrig();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule